// File: doc/BRIEF.md
# Word-Serial Eight-Operation Micro Core

This core takes its program as a stream of 6-bit words, one word on each rising clock edge. A sequencer counts the words and assembles each instruction from one, two or three of them, depending on the 3-bit operation code in the first word. The core has eight general registers of 8 bits and an 8-bit display output. It performs addition, bitwise AND and bitwise OR, each with either a second register or an 8-bit constant as the right operand. It also loads a constant into a register and copies a register to the display output.

After reset the core discards every word until it sees the all-ones word 0x3F. The word that follows this marker is the first word of the first instruction. From then on the core decodes words continuously with no gaps. Each instruction completes on the edge that samples its last word. The word on the next edge begins the next instruction.

Top module: `wordfed_cpu`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the edge it is sampled, all eight registers and `data_out` become 0 and the core returns to waiting for the start marker.
- R2: While the core is waiting, every word other than 0x3F is discarded and has no effect on registers or `data_out`. The word after 0x3F is taken as word 0 of the first instruction.
- R3: Word 0 holds the operation code in bits [5:3] and source register A in bits [2:0]. Code 000 is a one-word display instruction. It loads register A into `data_out` on the edge that samples that word.
- R4: Codes 001 (add), 011 (AND) and 101 (OR) take two words. Word 1 holds the destination in bits [5:3] and source register B in bits [2:0]. The destination receives A op B on the edge that samples word 1.
- R5: Codes 010 (add constant), 100 (AND constant) and 110 (OR constant) take three words. The constant is word1[2:0] followed by word2[4:0]. Bit 5 of word 2 is ignored. The destination named in word1[5:3] receives A op constant on the edge that samples word 2.
- R6: Code 111 takes three words and writes the constant alone into the destination. Source field A is ignored.
- R7: Addition wraps modulo 256, and no carry is kept anywhere.
- R8: Once started, the core decodes 0x3F as an ordinary word, that is, as a load whose A field is 7. It is never taken as a new marker.
- R9: `data_out` changes only on a display instruction and otherwise holds its value.
- R10: Instructions follow back to back. The word after an instruction's last word is word 0 of the next one. A destination equal to a source uses the source's value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one instruction word sampled per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| word_in | input | 6 | Instruction word stream |
| data_out | output | 8 | Display register, written by the display instruction |

## Verification
The hardest situation to reach is the all-ones word arriving after start. A sequencer that keeps looking for the marker would silently resynchronise there. The stimulus therefore feeds 0x3F as word 0 of a load. It then reads the target register back with a display instruction. Register contents are only visible through the display output. For that reason every arithmetic, logic and load result is followed by a display instruction. The scoreboard also expects an unchanged `data_out` on every non-display word, which exercises R9 on every cycle.

// File: rtl/wfc_pkg.sv
package wfc_pkg;
    localparam int WORD_W = 6;
    localparam int DATA_W = 8;
    localparam int REG_N  = 8;
    localparam int IDX_W  = $clog2(REG_N);
    localparam logic [WORD_W-1:0] START_MARK = '1;

    typedef enum logic [2:0] {
        OP_SHOW = 3'b000,
        OP_ADD  = 3'b001,
        OP_ADDK = 3'b010,
        OP_AND  = 3'b011,
        OP_ANDK = 3'b100,
        OP_OR   = 3'b101,
        OP_ORK  = 3'b110,
        OP_LOAD = 3'b111
    } op_e;

    typedef enum logic [1:0] {
        SQ_WAIT,
        SQ_W0,
        SQ_W1,
        SQ_W2
    } seq_e;

    typedef struct packed {
        logic              fire;
        op_e               op;
        logic [IDX_W-1:0]  dst;
        logic [IDX_W-1:0]  ra;
        logic [IDX_W-1:0]  rb;
        logic [DATA_W-1:0] imm;
    } issue_t;

    function automatic logic [1:0] word_count(input op_e op);
        case (op)
            OP_SHOW:                 return 2'd1;
            OP_ADD, OP_AND, OP_OR:   return 2'd2;
            default:                 return 2'd3;
        endcase
    endfunction

    function automatic logic takes_const(input op_e op);
        return (op == OP_ADDK) || (op == OP_ANDK) || (op == OP_ORK) || (op == OP_LOAD);
    endfunction
endpackage

// File: rtl/wfc_seq.sv
module wfc_seq
    import wfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word,
    output issue_t            iss
);
    seq_e             st, st_nx;
    op_e              op_q;
    logic [IDX_W-1:0] ra_q, dst_q, lo_q;
    op_e              op_w;

    assign op_w = op_e'(word[WORD_W-1:WORD_W-3]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SQ_WAIT;
            op_q  <= OP_SHOW;
            ra_q  <= '0;
            dst_q <= '0;
            lo_q  <= '0;
        end else begin
            st <= st_nx;
            case (st)
                SQ_W0: begin
                    op_q <= op_w;
                    ra_q <= word[2:0];
                end
                SQ_W1: begin
                    dst_q <= word[WORD_W-1:WORD_W-3];
                    lo_q  <= word[2:0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        st_nx    = st;
        iss      = '0;
        iss.op   = op_q;
        iss.ra   = ra_q;
        iss.dst  = dst_q;
        iss.rb   = lo_q;
        iss.imm  = {lo_q, word[4:0]};
        case (st)
            SQ_WAIT: begin
                if (word == START_MARK) st_nx = SQ_W0;
            end
            SQ_W0: begin
                iss.op = op_w;
                iss.ra = word[2:0];
                if (word_count(op_w) == 2'd1) begin
                    iss.fire = 1'b1;
                    st_nx    = SQ_W0;
                end else begin
                    st_nx = SQ_W1;
                end
            end
            SQ_W1: begin
                iss.dst = word[WORD_W-1:WORD_W-3];
                iss.rb  = word[2:0];
                if (word_count(op_q) == 2'd2) begin
                    iss.fire = 1'b1;
                    st_nx    = SQ_W0;
                end else begin
                    st_nx = SQ_W2;
                end
            end
            default: begin
                iss.fire = 1'b1;
                st_nx    = SQ_W0;
            end
        endcase
    end

    // R2: the marker moves the sequencer to word 0
    a_r2_marker_starts: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_WAIT && word == START_MARK) |=> (st == SQ_W0));
    // R2: any other word keeps it waiting
    a_r2_wait_holds: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_WAIT && word != START_MARK) |=> (st == SQ_WAIT));
    // R8: once started, never back to waiting without reset
    a_r8_no_rearm: assert property (@(posedge clk) disable iff (rst)
        (st != SQ_WAIT) |=> (st != SQ_WAIT));
    // R10: after completion the next word is word 0
    a_r10_back_to_back: assert property (@(posedge clk) disable iff (rst)
        iss.fire |=> (st == SQ_W0));
    // R5: a constant instruction completes only from the third word
    a_r5_third_word: assert property (@(posedge clk) disable iff (rst)
        (iss.fire && takes_const(iss.op)) |-> (st == SQ_W2));
endmodule

// File: rtl/wfc_rf.sv
module wfc_rf #(
    parameter int N = 8,
    parameter int W = 8,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (we && waddr == AW'(i)) begin
                regs[i] <= wdata;
            end
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

    // R4: a write lands in the addressed register on the next cycle
    a_r4_commit: assert property (@(posedge clk) disable iff (rst)
        we |=> (regs[$past(waddr)] == $past(wdata)));
    // R1: registers untouched when no write is issued
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !we |=> (regs[$past(raddr_a)] == $past(rdata_a)));
endmodule

// File: rtl/wfc_alu.sv
module wfc_alu
    import wfc_pkg::*;
(
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] imm,
    output logic [DATA_W-1:0] y,
    output logic              writes
);
    logic [DATA_W-1:0] rhs;

    always_comb begin
        rhs    = takes_const(op) ? imm : b;
        writes = (op != OP_SHOW);
        case (op)
            OP_ADD, OP_ADDK: y = a + rhs;
            OP_AND, OP_ANDK: y = a & rhs;
            OP_OR,  OP_ORK:  y = a | rhs;
            OP_LOAD:         y = rhs;
            default:         y = a;
        endcase
    end
endmodule

// File: rtl/wordfed_cpu.sv
module wordfed_cpu
    import wfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_in,
    output logic [DATA_W-1:0] data_out
);
    issue_t            iss;
    logic [DATA_W-1:0] val_a, val_b, result;
    logic              alu_writes;
    logic              show_now;

    wfc_seq u_seq (
        .clk  (clk),
        .rst  (rst),
        .word (word_in),
        .iss  (iss)
    );

    wfc_rf #(.N(REG_N), .W(DATA_W)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (iss.fire && alu_writes),
        .waddr   (iss.dst),
        .wdata   (result),
        .raddr_a (iss.ra),
        .raddr_b (iss.rb),
        .rdata_a (val_a),
        .rdata_b (val_b)
    );

    wfc_alu u_alu (
        .op     (iss.op),
        .a      (val_a),
        .b      (val_b),
        .imm    (iss.imm),
        .y      (result),
        .writes (alu_writes)
    );

    assign show_now = iss.fire && (iss.op == OP_SHOW);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_out <= '0;
        end else if (show_now) begin
            data_out <= val_a;
        end
    end

    // R9: output holds unless a display completes
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !show_now |=> $stable(data_out));
    // R3: display presents the selected register one edge later
    a_r3_show: assert property (@(posedge clk) disable iff (rst)
        show_now |=> (data_out == $past(val_a)));
endmodule

// File: tb/wordfed_cpu_test.sv
`timescale 1ns/1ps
module wordfed_cpu_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] word_in = '0;
    logic [7:0] data_out;

    always #2.5 clk = ~clk;

    wordfed_cpu uut (
        .clk      (clk),
        .rst      (rst),
        .word_in  (word_in),
        .data_out (data_out)
    );

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t      q[$];
    item_t      cur;
    int         checks = 0;
    int         errors = 0;
    logic [7:0] m [8];
    logic [7:0] exp_dout = '0;
    bit         done = 0;

    // monitor: one expected item per driven word, sampled 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            cur = q.pop_front();
            checks++;
            if (data_out !== cur.exp) begin
                errors++;
                $display("FAIL %s: data_out=%02h expected=%02h at %0t", cur.tag, data_out, cur.exp, $time);
            end
        end
    end

    function automatic logic [7:0] calc(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
        case (op)
            3'b001, 3'b010: return a + b;
            3'b011, 3'b100: return a & b;
            3'b101, 3'b110: return a | b;
            default:        return b;
        endcase
    endfunction

    task automatic put(input logic [5:0] w, input string tag);
        @(negedge clk);
        word_in = w;
        q.push_back('{exp_dout, tag});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        word_in = '0;
        for (int i = 0; i < 8; i++) m[i] = '0;
        exp_dout = '0;
        q.push_back('{exp_dout, "R1"});
        @(negedge clk);
        q.push_back('{exp_dout, "R1"});
        @(negedge clk);
        rst = 1'b0;
        q.push_back('{exp_dout, "R1"});
    endtask

    task automatic show(input logic [2:0] a, input string tag);
        exp_dout = m[a];
        put({3'b000, a}, tag);
    endtask

    task automatic rr(input logic [2:0] op, input logic [2:0] d, input logic [2:0] a,
                      input logic [2:0] b, input string tag);
        logic [7:0] r;
        r = calc(op, m[a], m[b]);
        put({op, a}, tag);
        put({d, b}, tag);
        m[d] = r;
    endtask

    task automatic kop(input logic [2:0] op, input logic [2:0] d, input logic [2:0] a,
                       input logic [7:0] k, input logic x, input string tag);
        logic [7:0] r;
        r = calc(op, m[a], k);
        put({op, a}, tag);
        put({d, k[7:5]}, tag);
        put({x, k[4:0]}, tag);
        m[d] = r;
    endtask

    initial begin
        do_reset();
        // R2: junk before the marker, including a load and displays
        put(6'h38, "R2"); put(6'h0F, "R2"); put(6'h1F, "R2");
        put(6'h07, "R2"); put(6'h00, "R2");
        put(6'h3F, "R2");
        show(3'd1, "R2");
        // R6: loads, A field nonzero and ignored
        kop(3'b111, 3'd1, 3'd5, 8'hA5, 1'b0, "R6");
        show(3'd1, "R6");
        kop(3'b111, 3'd2, 3'd0, 8'h5C, 1'b1, "R6");
        show(3'd2, "R6");
        // R7: wrap of add
        rr(3'b001, 3'd3, 3'd1, 3'd2, "R7");
        show(3'd3, "R7");
        // R4: register AND / OR
        rr(3'b011, 3'd4, 3'd1, 3'd2, "R4");
        show(3'd4, "R4");
        rr(3'b101, 3'd5, 3'd1, 3'd2, "R4");
        show(3'd5, "R4");
        // R5: constant forms, top bit of word 2 set as don't-care
        kop(3'b010, 3'd6, 3'd1, 8'h7F, 1'b1, "R5");
        show(3'd6, "R5");
        kop(3'b100, 3'd7, 3'd2, 8'hF0, 1'b1, "R5");
        show(3'd7, "R5");
        kop(3'b110, 3'd0, 3'd0, 8'h81, 1'b0, "R5");
        show(3'd0, "R5");
        // R9: several non-display instructions, output must hold
        rr(3'b001, 3'd4, 3'd4, 3'd5, "R9");
        kop(3'b100, 3'd5, 3'd5, 8'h3C, 1'b0, "R9");
        rr(3'b101, 3'd6, 3'd6, 3'd7, "R9");
        show(3'd4, "R9"); show(3'd5, "R9"); show(3'd6, "R9");
        // R10: destination equal to source
        rr(3'b001, 3'd1, 3'd1, 3'd1, "R10");
        show(3'd1, "R10");
        // R8: 0x3F after start is a load with A field 7
        put(6'h3F, "R8");
        put({3'd2, 3'b110}, "R8");
        put(6'h2B, "R8");
        m[2] = 8'hCB;
        show(3'd2, "R8");
        // R3: display of each register
        for (int i = 0; i < 8; i++) show(3'(i), "R3");
        // R1: reset clears everything and re-arms the marker wait
        do_reset();
        put(6'h00, "R1"); put(6'h3E, "R1");
        put(6'h3F, "R1");
        for (int i = 0; i < 8; i++) show(3'(i), "R1");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule